// File: doc/BRIEF.md
# Carrier Sense Activity Serializer

This block watches nine carrier-sense inputs on a repeater: one for the attachment-unit port and one for each of the eight twisted-pair ports. Once per fixed sample period it sends their states out as a short serial frame on one data pin. A second pin pulses once to mark the end of each frame. An external serial-in/parallel-out register, clocked by the same bit clock, shifts the data pin in. It then transfers the nine bits to its parallel outputs when the strobe pin is high.

Each channel has a sticky flag, so the frame also reports activity that came and went inside a period. A channel that was active for a single bit time still shows as set in the next frame. The inputs pass through a two-flop synchronizer before they reach the sticky logic. The block counts one bit time per clock cycle, and the default period is ten bit times: nine data slots followed by one strobe slot.

Top module: `csa_serializer`

## Requirements
- R1: A synchronous active-high reset drives `ser_data` and `ser_strobe` low from the next clock onward. It clears every sticky flag, the synchronizer and the frame register, and restarts the period counter at slot 0.
- R2: `ser_strobe` is high for exactly one clock in every `PERIOD` clocks, and never on two consecutive clocks.
- R3: Channel mapping is fixed. `carrier_in[0]` is the attachment-unit port and `carrier_in[k]` is twisted-pair port k-1. A frame drives bits in slots 0 to 8: `carrier_in[8]` (TP7) first, down to TP0 in slot 7, and the attachment-unit bit last in slot 8.
- R4: The strobe occupies the slot right after the last data bit. `ser_data` is low in the strobe slot and in any idle slot.
- R5: A carrier pulse as short as one clock, at any point in a period, is reported as a 1 in a later frame.
- R6: At each period boundary a channel's sticky flag clears unless its synchronized carrier is still high. After a carrier drops, the channel reads 0 from the third frame that follows onward.
- R7: A carrier event that arrives while a frame is being shifted out leaves that frame unchanged. The event shows only in a later frame.
- R8: A raw input reaches the frame logic after two clocks of synchronization. The reference sequence on both outputs equals the one produced with that two-clock lag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one cycle per bit time |
| rst | input | 1 | Synchronous active-high reset |
| carrier_in | input | 9 | Raw carrier-sense per channel, bit 0 attachment-unit port, bits 1 to 8 TP0 to TP7 |
| ser_data | output | 1 | Serial frame data, TP7 first, attachment-unit bit last |
| ser_strobe | output | 1 | One-cycle end-of-frame marker |

## Verification
The hardest case to reach from the ports is a pulse that rises and falls within one period while an earlier frame is still shifting out. Such a pulse must appear in the next frame but one, and must not leak into the frame already on the wire. The bench reaches it by aligning to an observed strobe and raising one channel for a single clock at that point. It then rebuilds the next three frames with its own deserializer. A channel held high across several frames and then dropped exercises the sticky-clear path. Long stretches of sparse random pulses are compared on every clock against a behavioural model that uses a bit queue.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // Default geometry of the activity report
  localparam int unsigned CSA_NUM_CH = 9;
  localparam int unsigned CSA_PERIOD = 10;
  localparam int unsigned CSA_SYNC_STAGES = 2;
  // Channel index of the attachment-unit port; twisted-pair k sits at k+1
  localparam int unsigned CSA_AUI_IDX = 0;
endpackage

// File: rtl/csa_sync.sv
module csa_sync #(
  parameter int unsigned NUM_CH = csa_pkg::CSA_NUM_CH,
  parameter int unsigned STAGES = csa_pkg::CSA_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] raw_i,
  output logic [NUM_CH-1:0] sync_o
);
  logic [STAGES-1:0][NUM_CH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/csa_sticky.sv
module csa_sticky #(
  parameter int unsigned NUM_CH = csa_pkg::CSA_NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] sync_i,
  input  logic              period_end_i,
  output logic [NUM_CH-1:0] frame_o
);
  logic [NUM_CH-1:0] seen_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)               seen_q[c] <= 1'b0;
      else if (period_end_i) seen_q[c] <= sync_i[c];
      else                   seen_q[c] <= seen_q[c] | sync_i[c];
    end

    assign frame_o[c] = seen_q[c] | sync_i[c];

    // R5
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
      sync_i[c] |=> seen_q[c]);

    // R6
    sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (period_end_i && !sync_i[c]) |=> !seen_q[c]);
  end
endmodule

// File: rtl/csa_framer.sv
module csa_framer #(
  parameter int unsigned NUM_CH = csa_pkg::CSA_NUM_CH,
  parameter int unsigned PERIOD = csa_pkg::CSA_PERIOD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] frame_i,
  output logic              period_end_o,
  output logic              sdata_o,
  output logic              strobe_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST_SLOT = CW'(PERIOD - 1);
  localparam logic [CW-1:0] LAST_DATA = CW'(NUM_CH - 1);

  logic [CW-1:0]     slot_q;
  logic [NUM_CH-1:0] shreg_q;
  logic              sdata_q;
  logic              strobe_q;
  logic              last;

  assign last = (slot_q == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      shreg_q  <= '0;
      sdata_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      slot_q   <= last ? '0 : slot_q + 1'b1;
      strobe_q <= (slot_q == LAST_DATA);
      if (last) begin
        sdata_q <= frame_i[NUM_CH-1];
        shreg_q <= frame_i << 1;
      end else if (slot_q < LAST_DATA) begin
        sdata_q <= shreg_q[NUM_CH-1];
        shreg_q <= shreg_q << 1;
      end else begin
        sdata_q <= 1'b0;
      end
    end
  end

  assign period_end_o = last;
  assign sdata_o      = sdata_q;
  assign strobe_o     = strobe_q;

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_q |=> !strobe_q);

  // R4
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> !sdata_q);
endmodule

// File: rtl/csa_serializer.sv
module csa_serializer #(
  parameter int unsigned NUM_CH      = csa_pkg::CSA_NUM_CH,
  parameter int unsigned PERIOD      = csa_pkg::CSA_PERIOD,
  parameter int unsigned SYNC_STAGES = csa_pkg::CSA_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] carrier_in,
  output logic              ser_data,
  output logic              ser_strobe
);
  logic [NUM_CH-1:0] carrier_sync;
  logic [NUM_CH-1:0] frame_bits;
  logic              period_end;

  csa_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (carrier_in),
    .sync_o (carrier_sync)
  );

  csa_sticky #(.NUM_CH(NUM_CH)) u_sticky (
    .clk          (clk),
    .rst          (rst),
    .sync_i       (carrier_sync),
    .period_end_i (period_end),
    .frame_o      (frame_bits)
  );

  csa_framer #(.NUM_CH(NUM_CH), .PERIOD(PERIOD)) u_framer (
    .clk          (clk),
    .rst          (rst),
    .frame_i      (frame_bits),
    .period_end_o (period_end),
    .sdata_o      (ser_data),
    .strobe_o     (ser_strobe)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!ser_data && !ser_strobe));
endmodule

// File: tb/csa_serializer_bench.sv
module csa_serializer_bench;
  localparam int N = 9;
  localparam int P = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] carrier_in = '0;
  logic         ser_data;
  logic         ser_strobe;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  csa_serializer u_csa_serializer (
    .clk        (clk),
    .rst        (rst),
    .carrier_in (carrier_in),
    .ser_data   (ser_data),
    .ser_strobe (ser_strobe)
  );

  // Behavioural reference: integer slot counter and a queue of pending bits
  bit       m_lag1 [N];
  bit       m_lag2 [N];
  bit       m_seen [N];
  int       m_slot;
  bit       m_sd, m_st;
  bit       pending[$];

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_lag1[i]) begin m_lag1[i] = 0; m_lag2[i] = 0; m_seen[i] = 0; end
      m_slot = 0; m_sd = 0; m_st = 0; pending.delete();
    end else begin
      bit word [N];
      bit boundary;
      boundary = (m_slot == P - 1);
      for (int i = 0; i < N; i++) word[i] = m_lag2[i] | m_seen[i];
      for (int i = 0; i < N; i++)
        m_seen[i] = boundary ? m_lag2[i] : (m_seen[i] | m_lag2[i]);
      m_st = (m_slot == N - 1);
      if (boundary) begin
        pending.delete();
        m_sd = word[N-1];
        for (int i = N - 2; i >= 0; i--) pending.push_back(word[i]);
      end else if (m_slot < N - 1 && pending.size() > 0) begin
        m_sd = pending.pop_front();
      end else begin
        m_sd = 0;
      end
      m_slot = boundary ? 0 : m_slot + 1;
      for (int i = 0; i < N; i++) begin
        m_lag2[i] = m_lag1[i];
        m_lag1[i] = carrier_in[i];
      end
    end
  end

  // Per-clock comparison and external deserializer
  logic [N-1:0] acc = '0;
  logic [N-1:0] captured = '0;
  bit           strobe_seen = 0;
  bit           compare_on = 0;

  always @(negedge clk) begin
    strobe_seen = 0;
    if (compare_on) begin
      tests++;
      if (ser_data !== m_sd || ser_strobe !== m_st) begin
        fails++;
        $display("FAIL R8/R3/R4 data=%b strobe=%b expected data=%b strobe=%b",
                 ser_data, ser_strobe, m_sd, m_st);
      end
    end
    if (ser_strobe) begin
      captured = acc;
      strobe_seen = 1;
    end else begin
      acc = {acc[N-2:0], ser_data};
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic next_frame(output logic [N-1:0] w);
    do begin
      @(negedge clk); #1;
    end while (!strobe_seen);
    w = captured;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] w;
    int gap;
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs quiet under reset
    check(ser_data === 1'b0 && ser_strobe === 1'b0, "R1 reset outputs",
          {ser_data, ser_strobe}, 0);
    @(negedge clk);
    rst = 1'b0;
    compare_on = 1;

    // R2: strobe spacing
    next_frame(w);
    gap = 0;
    do begin @(negedge clk); #1; gap++; end while (!strobe_seen);
    check(gap == P, "R2 strobe period", gap, P);

    // R3: ordering, TP7 and AUI set only
    carrier_in = 9'b1_0000_0001;
    next_frame(w); next_frame(w); next_frame(w);
    check(w == 9'b1_0000_0001, "R3 bit order", w, 9'h101);
    // R4: data low in the strobe slot
    check(ser_data === 1'b0, "R4 data low at strobe", ser_data, 0);
    carrier_in = '0;

    // R6: held carrier then drop
    next_frame(w); next_frame(w); next_frame(w);
    carrier_in[0] = 1'b1;
    next_frame(w); next_frame(w); next_frame(w);
    check(w[0] == 1'b1, "R6 held carrier reported", w, 1);
    carrier_in[0] = 1'b0;
    next_frame(w);
    check(w[0] == 1'b1, "R6 first frame after drop", w, 1);
    next_frame(w);
    check(w[0] == 1'b1, "R6 sticky frame after drop", w, 1);
    next_frame(w);
    check(w[0] == 1'b0, "R6 cleared after report", w, 0);

    // R5 and R7: single-clock pulse on TP3 raised at the strobe slot
    next_frame(w);
    carrier_in[4] = 1'b1;
    @(negedge clk);
    carrier_in[4] = 1'b0;
    next_frame(w);
    check(w == '0, "R7 in-flight frame unchanged", w, 0);
    next_frame(w);
    check(w == 9'b0_0001_0000, "R5 short pulse captured", w, 9'h010);
    next_frame(w);
    check(w == '0, "R6 pulse cleared next frame", w, 0);

    // R8: sparse random pulses compared every clock
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      carrier_in = '0;
      if (($urandom % 8) == 0) carrier_in[$urandom % N] = 1'b1;
      if (($urandom % 50) == 0) carrier_in = '1;
    end
    carrier_in = '0;

    // R1: reset in mid-run with activity present
    carrier_in = '1;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #1;
    check(ser_data === 1'b0 && ser_strobe === 1'b0, "R1 mid-run reset",
          {ser_data, ser_strobe}, 0);
    carrier_in = '0;
    @(negedge clk);
    rst = 1'b0;
    next_frame(w); next_frame(w);
    check(w == '0, "R1 sticky cleared by reset", w, 0);

    repeat (20) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule